// File: doc/BRIEF.md
# Banked Latch Transceiver

This block links one narrow A port to two wide-side banks, bank 1 and bank 2, each as wide as the A port. Level-sensitive storage latches sit on both paths. Going outward, two latch enables each capture the A bus into one bank's latch. Each bank has its own active-low output enable, so either bank, both or neither drives.

Going inward, each bank's incoming bus is caught by a latch of its own. A bank select chooses which of those two latches feeds A, behind an active-low A output enable. The block is typically used to interleave address and data, or two memory banks, onto one narrow path.

Each bidirectional pad is split into an input bus, an output bus and a drive flag. An optional keeper register gives the last value the port actually drove while the port is not driving. This stands in for bus hold. A clock is needed only by the keepers and by the reset synchronizer. The latches themselves are purely level-sensitive.

Top module: `mux_latch_xcvr`

## Requirements
- R1: While the internal reset is active, all four latches and all keepers are cleared. Every output bus reads zero. The internal reset is asserted at once by `rst_n` low and is released on the second rising clock edge after `rst_n` goes high.
- R2: While `le_a2b1` is high and `oe_b1_n` is low, `b1_o` follows `a_i` with no clock delay.
- R3: When a latch enable falls, that latch keeps the value present at the fall for as long as the enable stays low. Later changes on its data input do not reach the output.
- R4: `le_a2b1` and `le_a2b2` act independently. Both high captures the same `a_i` into both banks. One high leaves the other bank's latch unchanged.
- R5: `le_b12a` latches `b1_i` and `le_b22a` latches `b2_i`. Each is transparent while its enable is high.
- R6: With `oe_a_n` low, `a_o` shows the bank-1 inward latch when `bank_sel` is 1 and the bank-2 inward latch when `bank_sel` is 0. Switching `bank_sel` changes `a_o` in the same cycle.
- R7: All output enables are active low. Each drive flag (`a_drv`, `b1_drv`, `b2_drv`) is the inverse of its enable. `oe_b1_n` and `oe_b2_n` are independent of each other.
- R8: While a port is not driving, its output bus shows the value it presented at the last rising clock edge at which it was driving. The value is zero if it has not driven since reset.
- R9: Toggling an output enable leaves the latched data untouched. Re-enabling shows the held value again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for keepers and reset synchronizer |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | 12 | Incoming value on the A pad |
| b1_i | input | 12 | Incoming value on the bank-1 pad |
| b2_i | input | 12 | Incoming value on the bank-2 pad |
| le_a2b1 | input | 1 | Latch enable, A into bank-1 outward latch |
| le_a2b2 | input | 1 | Latch enable, A into bank-2 outward latch |
| le_b12a | input | 1 | Latch enable, bank 1 into its inward latch |
| le_b22a | input | 1 | Latch enable, bank 2 into its inward latch |
| bank_sel | input | 1 | 1 picks the bank-1 inward latch for A, 0 picks bank 2 |
| oe_a_n | input | 1 | Active-low output enable of A |
| oe_b1_n | input | 1 | Active-low output enable of bank 1 |
| oe_b2_n | input | 1 | Active-low output enable of bank 2 |
| a_o | output | 12 | Value presented on A |
| a_drv | output | 1 | A pad drive flag |
| b1_o | output | 12 | Value presented on bank 1 |
| b1_drv | output | 1 | Bank-1 pad drive flag |
| b2_o | output | 12 | Value presented on bank 2 |
| b2_drv | output | 1 | Bank-2 pad drive flag |

## Verification
The hardest condition to reach is both inward latches holding different values while `bank_sel` toggles. The stimulus first opens each inward latch separately, with distinct bank data. It closes each enable in a cycle of its own, then scrambles the incoming buses and flips the select. That way a wrongly transparent or wrongly routed latch shows up at once.

Keeper behaviour needs a port that drove a known value, was disabled, and then had its latch reloaded underneath it. The sequence does exactly that before re-enabling the port. A behavioural model in the bench tracks latches, keepers and the reset pipeline, and is compared with every output on every cycle.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    BANK_TWO = 1'b0,
    BANK_ONE = 1'b1
  } bank_sel_e;

  localparam int NUM_BANKS = 2;
endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic s1_q, s1_nxt;
  logic s2_q, s2_nxt;

  always_comb begin
    s1_nxt = 1'b1;
    s2_nxt = s1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= s1_nxt;
      s2_q <= s2_nxt;
    end
  end

  assign rst_q_n = s2_q;
endmodule

// File: rtl/xcvr_latch.sv
module xcvr_latch #(
  parameter int W = 12
) (
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_latch begin
    if (!rst_n) begin
      q = '0;
    end else if (en) begin
      q = d;
    end
  end
endmodule

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
  parameter int W    = 12,
  parameter bit KEEP = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         oe_n,
  input  logic [W-1:0] val,
  output logic [W-1:0] pad_o,
  output logic         drv
);
  logic drive;
  assign drive = ~oe_n;
  assign drv   = drive;

  generate
    if (KEEP) begin : g_keep
      logic [W-1:0] hold_q, hold_nxt;

      always_comb begin
        hold_nxt = hold_q;
        if (drive) hold_nxt = val;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_nxt;
      end

      assign pad_o = drive ? val : hold_q;

      // R8: an idle port must not change its presented value
      assert_keep_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n && $past(oe_n)) |-> $stable(pad_o));
    end else begin : g_nokeep
      assign pad_o = drive ? val : '0;
    end
  endgenerate
endmodule

// File: rtl/mux_latch_xcvr.sv
module mux_latch_xcvr
  import xcvr_pkg::*;
#(
  parameter int W    = 12,
  parameter bit KEEP = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b1_i,
  input  logic [W-1:0] b2_i,
  input  logic         le_a2b1,
  input  logic         le_a2b2,
  input  logic         le_b12a,
  input  logic         le_b22a,
  input  logic         bank_sel,
  input  logic         oe_a_n,
  input  logic         oe_b1_n,
  input  logic         oe_b2_n,
  output logic [W-1:0] a_o,
  output logic         a_drv,
  output logic [W-1:0] b1_o,
  output logic         b1_drv,
  output logic [W-1:0] b2_o,
  output logic         b2_drv
);
  localparam int NB = NUM_BANKS;

  logic rst_q_n;
  logic [NB-1:0][W-1:0] b_in, b_out, out_q, in_q;
  logic [NB-1:0]        out_le, in_le, b_oe_n, b_drv;
  logic [W-1:0]         a_sel;
  bank_sel_e            sel_e;

  xcvr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  assign b_in   = {b2_i, b1_i};
  assign out_le = {le_a2b2, le_a2b1};
  assign in_le  = {le_b22a, le_b12a};
  assign b_oe_n = {oe_b2_n, oe_b1_n};

  generate
    for (genvar g = 0; g < NB; g++) begin : g_bank
      xcvr_latch #(.W(W)) u_out_lat (
        .rst_n(rst_q_n), .en(out_le[g]), .d(a_i), .q(out_q[g]));
      xcvr_latch #(.W(W)) u_in_lat (
        .rst_n(rst_q_n), .en(in_le[g]), .d(b_in[g]), .q(in_q[g]));
      xcvr_keeper #(.W(W), .KEEP(KEEP)) u_bkeep (
        .clk(clk), .rst_n(rst_q_n), .oe_n(b_oe_n[g]), .val(out_q[g]),
        .pad_o(b_out[g]), .drv(b_drv[g]));
    end
  endgenerate

  assign sel_e = bank_sel_e'(bank_sel);
  always_comb begin
    unique case (sel_e)
      BANK_ONE: a_sel = in_q[0];
      default:  a_sel = in_q[1];
    endcase
  end

  xcvr_keeper #(.W(W), .KEEP(KEEP)) u_akeep (
    .clk(clk), .rst_n(rst_q_n), .oe_n(oe_a_n), .val(a_sel),
    .pad_o(a_o), .drv(a_drv));

  assign b1_o   = b_out[0];
  assign b2_o   = b_out[1];
  assign b1_drv = b_drv[0];
  assign b2_drv = b_drv[1];

  // R2: transparent outward path
  assert_b1_follow_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (le_a2b1 && !oe_b1_n) |-> (b1_o == a_i));
  // R3: closed outward latch holds its value
  assert_b1_hold_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!le_a2b1 && $past(!le_a2b1) && !oe_b1_n && $past(!oe_b1_n)) |-> $stable(b1_o));
  // R4: both banks capture the same word
  assert_dual_capture_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (le_a2b1 && le_a2b2 && !oe_b1_n && !oe_b2_n) |-> (b1_o == b2_o));
  // R6: select routes the open bank-1 inward latch to A
  assert_sel_bank1_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!oe_a_n && bank_sel && le_b12a) |-> (a_o == b1_i));
  assert_sel_bank2_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!oe_a_n && !bank_sel && le_b22a) |-> (a_o == b2_i));
  // R7: drive flags track active-low enables
  assert_drv_flags_R7: assert property (@(posedge clk)
    (a_drv != oe_a_n) && (b1_drv != oe_b1_n) && (b2_drv != oe_b2_n));
endmodule

// File: tb/mux_latch_xcvr_tb.sv
module mux_latch_xcvr_tb;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a_i, b1_i, b2_i;
  logic le_a2b1, le_a2b2, le_b12a, le_b22a, bank_sel;
  logic oe_a_n, oe_b1_n, oe_b2_n;
  logic [W-1:0] a_o, b1_o, b2_o;
  logic a_drv, b1_drv, b2_drv;

  always #2.5 clk = ~clk;

  mux_latch_xcvr #(.W(W), .KEEP(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .a_i(a_i), .b1_i(b1_i), .b2_i(b2_i),
    .le_a2b1(le_a2b1), .le_a2b2(le_a2b2), .le_b12a(le_b12a), .le_b22a(le_b22a),
    .bank_sel(bank_sel), .oe_a_n(oe_a_n), .oe_b1_n(oe_b1_n), .oe_b2_n(oe_b2_n),
    .a_o(a_o), .a_drv(a_drv), .b1_o(b1_o), .b1_drv(b1_drv),
    .b2_o(b2_o), .b2_drv(b2_drv));

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // behavioural model state
  logic rs1 = 1'b0, rs2 = 1'b0;
  logic [W-1:0] m_o1 = '0, m_o2 = '0, m_i1 = '0, m_i2 = '0;
  logic [W-1:0] k_a = '0, k_b1 = '0, k_b2 = '0;
  logic [W-1:0] e_a = '0, e_b1 = '0, e_b2 = '0;

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // keepers and reset pipeline advance on the rising edge
  always @(posedge clk) begin
    if (!rs2) begin
      k_a <= '0; k_b1 <= '0; k_b2 <= '0;
    end else begin
      if (!oe_a_n)  k_a  <= e_a;
      if (!oe_b1_n) k_b1 <= e_b1;
      if (!oe_b2_n) k_b2 <= e_b2;
    end
    rs1 <= rst_n;
    rs2 <= rst_n ? rs1 : 1'b0;
  end

  // latches evaluated and outputs compared away from the edge
  always @(negedge clk) begin
    logic [W-1:0] sel_v;
    if (!rst_n) begin rs1 = 1'b0; rs2 = 1'b0; end
    if (!rs2) begin
      m_o1 = '0; m_o2 = '0; m_i1 = '0; m_i2 = '0;
    end else begin
      if (le_a2b1) m_o1 = a_i;
      if (le_a2b2) m_o2 = a_i;
      if (le_b12a) m_i1 = b1_i;
      if (le_b22a) m_i2 = b2_i;
    end
    sel_v = bank_sel ? m_i1 : m_i2;
    e_a  = !rs2 ? '0 : (!oe_a_n  ? sel_v : k_a);
    e_b1 = !rs2 ? '0 : (!oe_b1_n ? m_o1  : k_b1);
    e_b2 = !rs2 ? '0 : (!oe_b2_n ? m_o2  : k_b2);
    if (!oe_a_n && !rs2)  e_a  = '0;
    chk({cur_req, " a_o"},  a_o,  e_a);
    chk({cur_req, " b1_o"}, b1_o, e_b1);
    chk({cur_req, " b2_o"}, b2_o, e_b2);
    chk("R7 drive flags", {{(W-3){1'b0}}, a_drv, b1_drv, b2_drv},
        {{(W-3){1'b0}}, ~oe_a_n, ~oe_b1_n, ~oe_b2_n});
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    a_i = 12'h5A5; b1_i = 12'h3C3; b2_i = 12'hC3C;
    le_a2b1 = 1'b1; le_a2b2 = 1'b1; le_b12a = 1'b1; le_b22a = 1'b1;
    bank_sel = 1'b1; oe_a_n = 1'b0; oe_b1_n = 1'b0; oe_b2_n = 1'b0;
    cur_req = "R1";
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R2: outward bank-1 transparency
    cur_req = "R2";
    le_a2b2 = 1'b0; le_b12a = 1'b0; le_b22a = 1'b0;
    tick(1); a_i = 12'h111; tick(1); a_i = 12'hABC; tick(1);
    // R3: close bank-1 latch, then move A
    cur_req = "R3";
    le_a2b1 = 1'b0; tick(1);
    a_i = 12'hF0F; tick(2); a_i = 12'h0F0; tick(1);
    // R4: simultaneous capture, then single-bank capture
    cur_req = "R4";
    a_i = 12'h246; tick(1);
    le_a2b1 = 1'b1; le_a2b2 = 1'b1; tick(1);
    le_a2b1 = 1'b0; le_a2b2 = 1'b0; tick(1);
    a_i = 12'h777; tick(1);
    le_a2b2 = 1'b1; tick(1); le_a2b2 = 1'b0; tick(1);
    a_i = 12'h888; tick(1);
    // R5: inward latches, each with its own data
    cur_req = "R5";
    b1_i = 12'h1A1; b2_i = 12'h2B2; tick(1);
    le_b12a = 1'b1; tick(1); le_b12a = 1'b0; tick(1);
    bank_sel = 1'b0; le_b22a = 1'b1; tick(1); le_b22a = 1'b0; tick(1);
    b1_i = 12'hEEE; b2_i = 12'hDDD; tick(1);
    // R6: flip select with both inward latches holding distinct values
    cur_req = "R6";
    for (int i = 0; i < 6; i++) begin
      bank_sel = ~bank_sel; tick(1);
    end
    // R7: independent bank enables
    cur_req = "R7";
    oe_b1_n = 1'b1; tick(1); oe_b2_n = 1'b1; tick(1);
    oe_b1_n = 1'b0; tick(1); oe_b2_n = 1'b0; oe_a_n = 1'b1; tick(1);
    oe_a_n = 1'b0; tick(1);
    // R8: keeper holds last driven value while latch underneath changes
    cur_req = "R8";
    oe_b1_n = 1'b1; oe_a_n = 1'b1; tick(1);
    a_i = 12'h9C9; tick(1); le_a2b1 = 1'b1; tick(1); le_a2b1 = 1'b0; tick(1);
    b1_i = 12'h4D4; le_b12a = 1'b1; bank_sel = 1'b1; tick(1); le_b12a = 1'b0; tick(2);
    // R9: re-enable reveals held latch contents
    cur_req = "R9";
    oe_b1_n = 1'b0; tick(1); oe_a_n = 1'b0; tick(2);
    oe_b2_n = 1'b1; tick(1); oe_b2_n = 1'b0; tick(2);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule